// File: doc/BRIEF.md
# Two-Digit Offset Frequency Readout

This block takes a binary frequency count from an external gated counter, one count per second, so one unit is 1 Hz. It adds or subtracts a stored intermediate-frequency offset, converts the result to decimal and drives a two-digit multiplexed seven-segment display. Only the thousands digit (1 kHz) and the hundreds digit (100 Hz) are shown. A decimal point follows the thousands digit, so a reading such as 17,106,200 Hz appears as "6.2".

Two strap inputs select how the offset is applied: as a sum, as one of two differences, or not at all. A push-button runs a calibration sequence. The first press shows the raw count with the thousands digit blinking while the operator tunes. The second press stores the latest raw count as the new offset through a write port and shows the fixed pattern "7.3". A third press returns to normal readout, and every later reading uses the stored offset.

Top module: `offset_readout`

## Requirements
- R1: With strapA=1 and strapB=1 the shown value is the count alone; the stored offset has no effect. The left digit is (value/1000) mod 10 and the right digit is (value/100) mod 10.
- R2: With strapA=1 and strapB=0 the shown value is count + offset, modulo 2^COUNT_W.
- R3: With strapA=0 and strapB=1 the shown value is count - offset, modulo 2^COUNT_W.
- R4: With strapA=0 and strapB=0 the shown value is offset - count, modulo 2^COUNT_W.
- R5: segs is active high with bit0..bit6 = segments a..g and bit7 = decimal point. The digit patterns are 0=3F, 1=06, 2=5B, 3=4F, 4=66, 5=6D, 6=7D, 7=07, 8=7F and 9=6F. digitEn=2'b10 selects the left (1 kHz) digit, which always carries the decimal point. digitEn=2'b01 selects the right (100 Hz) digit, which never does. Each digit is held for MUX_CYC cycles.
- R6: The first debounced press enters calibration. Readings then show the raw count and ignore the straps. The left digit is blanked (segs=0) for alternate periods of BLINK_HALF_CYC cycles.
- R7: The second press gives a single-cycle ofsWrEn pulse, with ofsWrData equal to the last raw count received. That value becomes the stored offset, and the display shows "7.3" (left 87h, right 4Fh).
- R8: The third press returns to normal readout without blinking. Readings that follow apply the newly stored offset.
- R9: A button level shorter than DEBOUNCE_CYC cycles is ignored. A held press acts exactly once.
- R10: After reset the display shows "0.0" (left BFh, right 3Fh), the stored offset is zero, the block is in normal readout and ofsWrEn is low.
- R11: A reading accepted on countValid reaches the display within COUNT_W+2 cycles. A countValid that arrives during a conversion is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| count | input | COUNT_W | Measured frequency count in Hz |
| countValid | input | 1 | Single-cycle strobe, count is new |
| button | input | 1 | Raw calibration push-button, high when pressed |
| strapA | input | 1 | Heterodyne strap A |
| strapB | input | 1 | Heterodyne strap B |
| segs | output | 8 | Segment drive {dp,g,f,e,d,c,b,a}, active high |
| digitEn | output | 2 | Digit enables, one-hot, bit1 = 1 kHz digit |
| ofsWrEn | output | 1 | Offset storage write strobe |
| ofsWrData | output | COUNT_W | Offset value to store |

## Verification
The bench keeps COUNT_W at 32, so carries reach the full 32-bit width and the all-ones count exercises the top of the decimal conversion. It shrinks DEBOUNCE_CYC to 4, MUX_CYC to 3 and BLINK_HALF_CYC to 40. With those values, short glitches, held presses, many multiplex periods and several blink phases all fit in a few hundred cycles. Offset arithmetic in all four strap settings is checked against a calibrated offset of 10,123,500.

// File: rtl/offset_readout_pkg.sv
package offset_readout_pkg;

  typedef enum logic [1:0] {
    CAL_IDLE = 2'd0,
    CAL_TUNE = 2'd1,
    CAL_DONE = 2'd2
  } calState_t;

  typedef struct packed {
    logic calMode;     // show raw count, ignore straps
    logic storeOfs;    // single-cycle: capture last raw count as offset
    logic showConfirm; // drive fixed confirmation pattern
    logic blankHi;     // blank the left digit (blink off phase)
    logic digitSel;    // 1 = left digit, 0 = right digit
  } ctlStrobe_t;

  function automatic logic [6:0] segOf(input logic [3:0] d);
    logic [6:0] s;
    case (d)
      4'd0: s = 7'h3F;
      4'd1: s = 7'h06;
      4'd2: s = 7'h5B;
      4'd3: s = 7'h4F;
      4'd4: s = 7'h66;
      4'd5: s = 7'h6D;
      4'd6: s = 7'h7D;
      4'd7: s = 7'h07;
      4'd8: s = 7'h7F;
      4'd9: s = 7'h6F;
      default: s = 7'h00;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/offset_readout_ctrl.sv
module offset_readout_ctrl
  import offset_readout_pkg::*;
#(
  parameter int DEBOUNCE_CYC   = 1000000,
  parameter int BLINK_HALF_CYC = 12500000,
  parameter int MUX_CYC        = 50000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       button,
  output ctlStrobe_t ctl
);

  localparam int DB_W  = $clog2(DEBOUNCE_CYC + 1);
  localparam int BL_W  = $clog2(BLINK_HALF_CYC + 1);
  localparam int MX_W  = $clog2(MUX_CYC + 1);

  // button synchroniser and debounce
  logic          btnMeta, btnSync;
  logic          btnStable;
  logic [DB_W-1:0] dbCnt;
  logic          pressPulse;

  always_ff @(posedge clk) begin
    if (rst) begin
      btnMeta    <= 1'b0;
      btnSync    <= 1'b0;
      btnStable  <= 1'b0;
      dbCnt      <= '0;
      pressPulse <= 1'b0;
    end else begin
      btnMeta    <= button;
      btnSync    <= btnMeta;
      pressPulse <= 1'b0;
      if (btnSync == btnStable) begin
        dbCnt <= '0;
      end else if (dbCnt == DB_W'(DEBOUNCE_CYC - 1)) begin
        dbCnt      <= '0;
        btnStable  <= btnSync;
        pressPulse <= btnSync;
      end else begin
        dbCnt <= dbCnt + 1'b1;
      end
    end
  end

  // calibration sequencer
  calState_t calState;
  logic      storeReq;

  always_ff @(posedge clk) begin
    if (rst) begin
      calState <= CAL_IDLE;
      storeReq <= 1'b0;
    end else begin
      storeReq <= 1'b0;
      if (pressPulse) begin
        case (calState)
          CAL_IDLE: calState <= CAL_TUNE;
          CAL_TUNE: begin
            calState <= CAL_DONE;
            storeReq <= 1'b1;
          end
          default:  calState <= CAL_IDLE;
        endcase
      end
    end
  end

  // blink timer, restarted visible on entry to tuning
  logic [BL_W-1:0] blinkCnt;
  logic            blinkOff;

  always_ff @(posedge clk) begin
    if (rst || calState != CAL_TUNE) begin
      blinkCnt <= '0;
      blinkOff <= 1'b0;
    end else if (blinkCnt == BL_W'(BLINK_HALF_CYC - 1)) begin
      blinkCnt <= '0;
      blinkOff <= ~blinkOff;
    end else begin
      blinkCnt <= blinkCnt + 1'b1;
    end
  end

  // digit multiplex timer
  logic [MX_W-1:0] muxCnt;
  logic            digitSel;

  always_ff @(posedge clk) begin
    if (rst) begin
      muxCnt   <= '0;
      digitSel <= 1'b1;
    end else if (muxCnt == MX_W'(MUX_CYC - 1)) begin
      muxCnt   <= '0;
      digitSel <= ~digitSel;
    end else begin
      muxCnt <= muxCnt + 1'b1;
    end
  end

  always_comb begin
    ctl.calMode     = (calState == CAL_TUNE);
    ctl.storeOfs    = storeReq;
    ctl.showConfirm = (calState == CAL_DONE);
    ctl.blankHi     = (calState == CAL_TUNE) && blinkOff;
    ctl.digitSel    = digitSel;
  end

  // R9: a press acts on one cycle only
  assert_press_single_R9: assert property (@(posedge clk) disable iff (rst)
    pressPulse |=> !pressPulse);

  // R6: press while idle enters tuning
  assert_enter_cal_R6: assert property (@(posedge clk) disable iff (rst)
    (calState == CAL_IDLE && pressPulse) |=> calState == CAL_TUNE);

  // R7: a store request is raised only on leaving tuning
  assert_store_from_tune_R7: assert property (@(posedge clk) disable iff (rst)
    storeReq |-> (calState == CAL_DONE && $past(calState) == CAL_TUNE));

  // R5: the digit select changes only at the end of a multiplex period
  assert_mux_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (muxCnt != '0) |-> $stable(digitSel));

endmodule

// File: rtl/offset_readout_dp.sv
module offset_readout_dp
  import offset_readout_pkg::*;
#(
  parameter int COUNT_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [COUNT_W-1:0] count,
  input  logic               countValid,
  input  logic               strapA,
  input  logic               strapB,
  input  ctlStrobe_t         ctl,
  output logic [7:0]         segs,
  output logic [1:0]         digitEn,
  output logic               ofsWrEn,
  output logic [COUNT_W-1:0] ofsWrData
);

  localparam int NDIG  = 4;            // units..thousands; higher never feed lower
  localparam int BCD_W = 4 * NDIG;
  localparam int CNT_W = $clog2(COUNT_W + 1);

  logic [COUNT_W-1:0] ofsReg;
  logic [COUNT_W-1:0] lastRaw;
  logic [COUNT_W-1:0] shiftReg;
  logic [BCD_W-1:0]   bcd;
  logic [BCD_W-1:0]   bcdAdj;
  logic [BCD_W-1:0]   bcdNext;
  logic [CNT_W-1:0]   bitCnt;
  logic               busy;
  logic [3:0]         dispHi, dispLo;
  logic [COUNT_W-1:0] shownValue;

  // heterodyne arrangement
  always_comb begin
    if (ctl.calMode) begin
      shownValue = count;
    end else begin
      case ({strapA, strapB})
        2'b11:   shownValue = count;
        2'b10:   shownValue = count + ofsReg;
        2'b01:   shownValue = count - ofsReg;
        default: shownValue = ofsReg - count;
      endcase
    end
  end

  // add-3 stage of shift-and-add-3 conversion, one per decimal digit
  for (genvar g = 0; g < NDIG; g++) begin : gAdj
    always_comb begin
      if (bcd[4*g +: 4] >= 4'd5) bcdAdj[4*g +: 4] = bcd[4*g +: 4] + 4'd3;
      else                       bcdAdj[4*g +: 4] = bcd[4*g +: 4];
    end
  end

  assign bcdNext = {bcdAdj[BCD_W-2:0], shiftReg[COUNT_W-1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      shiftReg <= '0;
      bcd      <= '0;
      bitCnt   <= '0;
      busy     <= 1'b0;
      lastRaw  <= '0;
      dispHi   <= '0;
      dispLo   <= '0;
    end else if (busy) begin
      shiftReg <= shiftReg << 1;
      bcd      <= bcdNext;
      bitCnt   <= bitCnt + 1'b1;
      if (bitCnt == CNT_W'(COUNT_W - 1)) begin
        busy   <= 1'b0;
        dispHi <= bcdNext[15:12];
        dispLo <= bcdNext[11:8];
      end
    end else if (countValid) begin
      shiftReg <= shownValue;
      bcd      <= '0;
      bitCnt   <= '0;
      busy     <= 1'b1;
      lastRaw  <= count;
    end
  end

  // offset storage (models the nonvolatile cell) and its write port
  always_ff @(posedge clk) begin
    if (rst) begin
      ofsReg    <= '0;
      ofsWrEn   <= 1'b0;
      ofsWrData <= '0;
    end else begin
      ofsWrEn <= ctl.storeOfs;
      if (ctl.storeOfs) begin
        ofsReg    <= lastRaw;
        ofsWrData <= lastRaw;
      end
    end
  end

  // segment and digit drive
  logic [3:0] hiDigit, loDigit;

  always_comb begin
    if (ctl.showConfirm) begin
      hiDigit = 4'd7;
      loDigit = 4'd3;
    end else begin
      hiDigit = dispHi;
      loDigit = dispLo;
    end
    if (ctl.digitSel) begin
      segs = ctl.blankHi ? 8'h00 : {1'b1, segOf(hiDigit)};
    end else begin
      segs = {1'b0, segOf(loDigit)};
    end
    digitEn = {ctl.digitSel, ~ctl.digitSel};
  end

  // R7: write strobe is a single cycle
  assert_wr_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    ofsWrEn |=> !ofsWrEn);

  // R7: stored offset matches what the write port presents
  assert_wr_match_R7: assert property (@(posedge clk) disable iff (rst)
    ofsWrEn |-> ofsReg == ofsWrData);

  // R6: blanking only happens while tuning
  assert_blank_in_cal_R6: assert property (@(posedge clk) disable iff (rst)
    ctl.blankHi |-> ctl.calMode);

  // R11: conversion step counter never runs past the word width
  assert_conv_bound_R11: assert property (@(posedge clk) disable iff (rst)
    busy |-> bitCnt < CNT_W'(COUNT_W));

  // R10: offset stays zero until the first write
  assert_ofs_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !ofsWrEn |-> $stable(ofsReg));

endmodule

// File: rtl/offset_readout.sv
module offset_readout
  import offset_readout_pkg::*;
#(
  parameter int COUNT_W        = 32,
  parameter int CLK_HZ         = 50000000,
  parameter int DEBOUNCE_CYC   = CLK_HZ / 50,
  parameter int BLINK_HALF_CYC = CLK_HZ / 4,
  parameter int MUX_CYC        = CLK_HZ / 1000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [COUNT_W-1:0] count,
  input  logic               countValid,
  input  logic               button,
  input  logic               strapA,
  input  logic               strapB,
  output logic [7:0]         segs,
  output logic [1:0]         digitEn,
  output logic               ofsWrEn,
  output logic [COUNT_W-1:0] ofsWrData
);

  ctlStrobe_t ctl;

  offset_readout_ctrl #(
    .DEBOUNCE_CYC  (DEBOUNCE_CYC),
    .BLINK_HALF_CYC(BLINK_HALF_CYC),
    .MUX_CYC       (MUX_CYC)
  ) u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .button(button),
    .ctl   (ctl)
  );

  offset_readout_dp #(
    .COUNT_W(COUNT_W)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .count     (count),
    .countValid(countValid),
    .strapA    (strapA),
    .strapB    (strapB),
    .ctl       (ctl),
    .segs      (segs),
    .digitEn   (digitEn),
    .ofsWrEn   (ofsWrEn),
    .ofsWrData (ofsWrData)
  );

endmodule

// File: tb/sim_offset_readout.sv
`timescale 1ns/1ps
module sim_offset_readout;

  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] count = '0;
  logic         countValid = 1'b0;
  logic         button = 1'b0;
  logic         strapA = 1'b1;
  logic         strapB = 1'b1;
  logic [7:0]   segs;
  logic [1:0]   digitEn;
  logic         ofsWrEn;
  logic [W-1:0] ofsWrData;

  int total = 0;
  int bad   = 0;
  int wrCount = 0;
  logic [W-1:0] wrSeen = '0;
  logic done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  offset_readout #(
    .COUNT_W(W), .CLK_HZ(1000), .DEBOUNCE_CYC(4),
    .BLINK_HALF_CYC(40), .MUX_CYC(3)
  ) u0 (
    .clk(clk), .rst(rst), .count(count), .countValid(countValid),
    .button(button), .strapA(strapA), .strapB(strapB),
    .segs(segs), .digitEn(digitEn), .ofsWrEn(ofsWrEn), .ofsWrData(ofsWrData)
  );

  always @(negedge clk) begin
    if (ofsWrEn) begin
      wrCount = wrCount + 1;
      wrSeen  = ofsWrData;
    end
  end

  function automatic logic [7:0] pat(input int d, input logic dp);
    logic [6:0] s;
    case (d)
      0: s = 7'h3F; 1: s = 7'h06; 2: s = 7'h5B; 3: s = 7'h4F; 4: s = 7'h66;
      5: s = 7'h6D; 6: s = 7'h7D; 7: s = 7'h07; 8: s = 7'h7F; default: s = 7'h6F;
    endcase
    return {dp, s};
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic readDisp(output logic [7:0] hi, output logic [7:0] lo);
    int guard = 0;
    @(negedge clk);
    while (digitEn != 2'b10 && guard < 50) begin @(negedge clk); guard++; end
    hi = segs;
    guard = 0;
    while (digitEn != 2'b01 && guard < 50) begin @(negedge clk); guard++; end
    lo = segs;
  endtask

  task automatic putCount(input logic [W-1:0] c);
    @(negedge clk);
    count = c; countValid = 1'b1;
    @(negedge clk);
    countValid = 1'b0;
    repeat (W + 6) @(negedge clk);
  endtask

  task automatic press(input int holdCyc);
    @(negedge clk);
    button = 1'b1;
    repeat (holdCyc) @(negedge clk);
    button = 1'b0;
    repeat (15) @(negedge clk);
  endtask

  // count blanked and lit left-digit samples over a window
  task automatic blinkScan(input int cyc, output int blank, output int lit);
    blank = 0; lit = 0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (digitEn == 2'b10) begin
        if (segs == 8'h00) blank++; else lit++;
      end
    end
  endtask

  typedef struct packed {
    logic [1:0]   straps;
    logic [W-1:0] cnt;
    logic [3:0]   hi;
    logic [3:0]   lo;
  } vec_t;

  // offset is 10123500 when this table runs
  localparam vec_t VECS [10] = '{
    '{2'b11, 32'd17106200, 4'd6, 4'd2},   // R1 offset ignored
    '{2'b11, 32'd999,      4'd0, 4'd9},   // R1
    '{2'b11, 32'd9900,     4'd9, 4'd9},   // R1
    '{2'b11, 32'hFFFFFFFF, 4'd7, 4'd2},   // R1 4294967295
    '{2'b10, 32'd7000000,  4'd3, 4'd5},   // R2 17123500
    '{2'b10, 32'd6982700,  4'd6, 4'd2},   // R2 17106200
    '{2'b01, 32'd17106200, 4'd2, 4'd7},   // R3 6982700
    '{2'b01, 32'd10124400, 4'd0, 4'd9},   // R3 900
    '{2'b00, 32'd3000000,  4'd3, 4'd5},   // R4 7123500
    '{2'b00, 32'd3140800,  4'd2, 4'd7}    // R4 6982700
  };

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] hi, lo;
    int nBlank, nLit, wrBefore;

    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    // R10 reset state
    readDisp(hi, lo);
    check("R10 left", hi, 8'hBF);
    check("R10 right", lo, 8'h3F);
    check("R10 wr", wrCount, 0);

    // R5 / R1 plain readout before calibration
    putCount(32'd17106200);
    readDisp(hi, lo);
    check("R5 left 6.", hi, pat(6, 1'b1));
    check("R5 right 2", lo, pat(2, 1'b0));

    // R11 countValid during a conversion is ignored
    @(negedge clk); count = 32'd4500; countValid = 1'b1;
    @(negedge clk); count = 32'd8800;
    @(negedge clk); countValid = 1'b0;
    repeat (W + 6) @(negedge clk);
    readDisp(hi, lo);
    check("R11 busy-ignore left", hi, pat(4, 1'b1));
    check("R11 busy-ignore right", lo, pat(5, 1'b0));

    // R6 enter calibration
    press(12);
    putCount(32'd10123500);
    blinkScan(300, nBlank, nLit);
    check("R6 blank seen", nBlank > 0, 1);
    check("R6 lit seen", nLit > 0, 1);
    readDisp(hi, lo);
    check("R6 right raw", lo, pat(5, 1'b0));
    check("R7 no write yet", wrCount, 0);

    // R7 store
    press(12);
    check("R7 single write", wrCount, 1);
    check("R7 write data", wrSeen, 32'd10123500);
    readDisp(hi, lo);
    check("R7 confirm left", hi, 8'h87);
    check("R7 confirm right", lo, 8'h4F);

    // R9 glitch shorter than debounce ignored
    @(negedge clk); button = 1'b1;
    @(negedge clk); @(negedge clk); button = 1'b0;
    repeat (20) @(negedge clk);
    readDisp(hi, lo);
    check("R9 glitch ignored", hi, 8'h87);

    // R9 / R8 long hold leaves confirmation once, no blinking after
    wrBefore = wrCount;
    press(150);
    blinkScan(300, nBlank, nLit);
    check("R8 no blink", nBlank, 0);
    readDisp(hi, lo);
    check("R9 held once", hi, pat(3, 1'b1));
    check("R9 no extra write", wrCount, wrBefore);

    // R1..R4, R8 table with stored offset
    foreach (VECS[i]) begin
      {strapA, strapB} = VECS[i].straps;
      putCount(VECS[i].cnt);
      readDisp(hi, lo);
      check($sformatf("R1-4 vec%0d left (R8)", i), hi, pat(VECS[i].hi, 1'b1));
      check($sformatf("R1-4 vec%0d right", i), lo, pat(VECS[i].lo, 1'b0));
    end
    // explicit tags for table coverage: R1 R2 R3 R4

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule